// File: doc/BRIEF.md
# Decode Stage Stall and Replay Controller

This block is the control logic of a superscalar decode stage. It sits between the fetch queue and the rename stage. Each cycle it takes a bundle of up to `W` instruction slots and passes the valid ones on to rename in the same cycle. Instructions are opaque records with a tag, a next-PC value and a few flags: control, target resolved, mispredicted, and no source registers.

When rename, issue/execute or commit asks for a stall, the stage stops forwarding. It parks incoming bundles in a bundle FIFO (the skid store) and holds fetch back. Once every stall is released, the parked bundles are replayed in arrival order before fetch is served again. Back-pressure on fetch stays on until the last parked bundle leaves.

A squash from commit empties the skid store and sends the stage to a squashing state. When a forwarded control instruction turns out to be mispredicted, the stage tells fetch to redirect to the corrected next PC. It then drops the rest of the bundle and everything parked.

Top module: `dec_stall_ctl`

## Requirements
- R1: After reset `mode` reads Idle. The `mode` encoding is Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4. `fe_stall`, `fe_squash` and every `rn_valid` bit are low while no bundle is presented.
- R2: In Idle or Running with no stall and no squash, slot i is forwarded in the same cycle only if slots 0..i are all valid. Forwarding stops at the first empty slot. A non-empty bundle moves Idle to Running.
- R3: Each forwarded slot carries its fetch tag unchanged. Its `rn_ready` bit equals that slot's no-source-register flag. Unforwarded slots have `rn_ready` low.
- R4: A stall input seen in Idle, Running or Unblocking gives no forwarding and `fe_stall` high in that cycle. The next state is Blocked, and the presented bundle is parked if its slot 0 is valid.
- R5: While Blocked, `fe_stall` is high and nothing is forwarded. Every bundle with slot 0 valid is parked.
- R6: In Blocked with all three stalls low, the next state is Unblocking if anything is parked, and Running otherwise. `fe_stall` stays high in that cycle.
- R7: In Unblocking, forwarding comes from the oldest parked bundle and fetch input is ignored. That bundle is removed. `fe_stall` stays high unless it was the last one, in which case the next state is Running.
- R8: Commit squash or ROB-squashing beats any stall. In that cycle nothing is forwarded, the skid store is emptied and the next state is Squashing. Squashing moves to Running only in a cycle where both indications are low, and it forwards nothing.
- R9: If a forwarded slot is a control instruction that is both resolved and mispredicted, that slot is still forwarded and the later slots are not. In the same cycle `fe_squash` and `fe_mispred` rise and `fe_npc` carries that slot's next PC. The skid store is emptied and the next state is Squashing.
- R10: `skid_ovf` is high only in a cycle where a park is attempted with `DEPTH` bundles already held. Parking up to `DEPTH` bundles keeps it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fq_vld | input | W | Slot valid from fetch |
| fq_ctl | input | W | Slot is a control instruction |
| fq_res | input | W | Slot target resolved |
| fq_mis | input | W | Slot found mispredicted |
| fq_nosrc | input | W | Slot has no source registers |
| fq_tag | input | W*TAG_W | Slot tags |
| fq_npc | input | W*PC_W | Slot next-PC values |
| stall_ren | input | 1 | Stall from rename |
| stall_iex | input | 1 | Stall from issue/execute |
| stall_cmt | input | 1 | Stall from commit |
| cmt_squash | input | 1 | Squash from commit |
| cmt_rob_sq | input | 1 | ROB squashing from commit |
| rn_valid | output | W | Forwarded slot valid |
| rn_ready | output | W | Forwarded slot ready to issue |
| rn_tag | output | W*TAG_W | Forwarded slot tags |
| fe_stall | output | 1 | Hold fetch |
| fe_squash | output | 1 | Redirect fetch |
| fe_mispred | output | 1 | Redirect caused by a mispredict |
| fe_npc | output | PC_W | Corrected next PC |
| mode | output | 3 | Controller state |
| skid_ovf | output | 1 | Park attempted while full |

## Verification
The bench fills the skid store to exactly `DEPTH` bundles and drains it. A wrong full test or count would raise `skid_ovf` early, replay bundles out of order, or drop `fe_stall` one bundle too soon. A squash is sent while bundles are parked, and a mispredict is planted inside a replayed bundle. After each, a stall and release with empty fetch must come back to Running, because a design that failed to empty the store would go to Unblocking and replay stale work. Squash and stall are raised together to show that squash wins. Bundles with holes, and with control slots that are resolved but not mispredicted, catch a forwarding mask that runs past an empty slot or fires on the wrong flags.

// File: rtl/dec_ctl_pkg.sv
package dec_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_BLK   = 3'd2,
    ST_UNB   = 3'd3,
    ST_SQ    = 3'd4
  } dec_state_e;
endpackage

// File: rtl/dec_skid_fifo.sv
module dec_skid_fifo #(
  parameter int BW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [BW-1:0] din,
  output logic [BW-1:0] dout,
  output logic          empty,
  output logic          last,
  output logic          ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [BW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign last    = (cnt_q == CW'(1));
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign ovf     = push & full;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/dec_slot_scan.sv
module dec_slot_scan #(
  parameter int W = 4
) (
  input  logic [W-1:0] vld,
  input  logic [W-1:0] ctl,
  input  logic [W-1:0] res,
  input  logic [W-1:0] mis,
  output logic [W-1:0] fwd,
  output logic [W-1:0] hit_vec
);
  logic [W:0]   alive;
  logic [W-1:0] bad;

  assign alive[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_slot
    assign bad[i]       = ctl[i] & res[i] & mis[i];
    assign fwd[i]       = alive[i] & vld[i];
    assign alive[i + 1] = fwd[i] & ~bad[i];
  end

  assign hit_vec = fwd & bad;
endmodule

// File: rtl/dec_stall_fsm.sv
module dec_stall_fsm
  import dec_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stall_any,
  input  logic       sq_any,
  input  logic       fetch_nz,
  input  logic       mis_hit,
  input  logic       skid_empty,
  input  logic       skid_last,
  output dec_state_e st_q,
  output logic       push,
  output logic       pop,
  output logic       flush,
  output logic       fwd_en,
  output logic       fe_stall
);
  dec_state_e st_d;

  always_comb begin
    st_d     = st_q;
    push     = 1'b0;
    pop      = 1'b0;
    flush    = 1'b0;
    fwd_en   = 1'b0;
    fe_stall = 1'b0;
    if (sq_any) begin
      flush = 1'b1;
      st_d  = ST_SQ;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_RUN: begin
          if (stall_any) begin
            push     = fetch_nz;
            fe_stall = 1'b1;
            st_d     = ST_BLK;
          end else begin
            fwd_en = 1'b1;
            if (mis_hit) begin
              flush = 1'b1;
              st_d  = ST_SQ;
            end else if (fetch_nz) begin
              st_d = ST_RUN;
            end
          end
        end
        ST_BLK: begin
          push     = fetch_nz;
          fe_stall = 1'b1;
          if (!stall_any) st_d = (!skid_empty || fetch_nz) ? ST_UNB : ST_RUN;
        end
        ST_UNB: begin
          if (stall_any) begin
            push     = fetch_nz;
            fe_stall = 1'b1;
            st_d     = ST_BLK;
          end else begin
            fwd_en = 1'b1;
            if (mis_hit) begin
              flush = 1'b1;
              st_d  = ST_SQ;
            end else begin
              pop      = 1'b1;
              fe_stall = ~skid_last;
              if (skid_last) st_d = ST_RUN;
            end
          end
        end
        ST_SQ:   st_d = ST_RUN;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // R8
  squash_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_any |=> (st_q == ST_SQ));

  // R5
  blocked_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BLK && !sq_any) |-> (fe_stall && !fwd_en));
endmodule

// File: rtl/dec_stall_ctl.sv
module dec_stall_ctl
  import dec_ctl_pkg::*;
#(
  parameter int W     = 4,
  parameter int TAG_W = 8,
  parameter int PC_W  = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     fq_vld,
  input  logic [W-1:0]     fq_ctl,
  input  logic [W-1:0]     fq_res,
  input  logic [W-1:0]     fq_mis,
  input  logic [W-1:0]     fq_nosrc,
  input  logic [W*TAG_W-1:0] fq_tag,
  input  logic [W*PC_W-1:0]  fq_npc,
  input  logic             stall_ren,
  input  logic             stall_iex,
  input  logic             stall_cmt,
  input  logic             cmt_squash,
  input  logic             cmt_rob_sq,
  output logic [W-1:0]     rn_valid,
  output logic [W-1:0]     rn_ready,
  output logic [W*TAG_W-1:0] rn_tag,
  output logic             fe_stall,
  output logic             fe_squash,
  output logic             fe_mispred,
  output logic [PC_W-1:0]  fe_npc,
  output logic [2:0]       mode,
  output logic             skid_ovf
);
  localparam int SW = 5 + TAG_W + PC_W;
  localparam int BW = W * SW;

  logic [BW-1:0] fq_bun, skid_dout, src;
  logic [W-1:0]  s_vld, s_ctl, s_res, s_mis, s_nos, fwd, hit_vec;
  logic [TAG_W-1:0] s_tag [W];
  logic [PC_W-1:0]  s_npc [W];
  logic stall_any, sq_any, mis_hit;
  logic push, pop, flush, fwd_en, skid_empty, skid_last;
  dec_state_e st_q;

  assign stall_any = stall_ren | stall_iex | stall_cmt;
  assign sq_any    = cmt_squash | cmt_rob_sq;

  for (genvar i = 0; i < W; i++) begin : g_pack
    assign fq_bun[i*SW +: SW] = {fq_npc[i*PC_W +: PC_W], fq_tag[i*TAG_W +: TAG_W],
                                 fq_nosrc[i], fq_mis[i], fq_res[i], fq_ctl[i], fq_vld[i]};
    assign s_vld[i] = src[i*SW];
    assign s_ctl[i] = src[i*SW + 1];
    assign s_res[i] = src[i*SW + 2];
    assign s_mis[i] = src[i*SW + 3];
    assign s_nos[i] = src[i*SW + 4];
    assign s_tag[i] = src[i*SW + 5 +: TAG_W];
    assign s_npc[i] = src[i*SW + 5 + TAG_W +: PC_W];
    assign rn_valid[i] = fwd_en & fwd[i];
    assign rn_ready[i] = rn_valid[i] & s_nos[i];
    assign rn_tag[i*TAG_W +: TAG_W] = rn_valid[i] ? s_tag[i] : '0;
  end

  assign src = (st_q == ST_UNB) ? skid_dout : fq_bun;

  dec_slot_scan #(.W(W)) u_scan (
    .vld     (s_vld),
    .ctl     (s_ctl),
    .res     (s_res),
    .mis     (s_mis),
    .fwd     (fwd),
    .hit_vec (hit_vec)
  );

  assign mis_hit = |hit_vec;

  dec_stall_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall_any  (stall_any),
    .sq_any     (sq_any),
    .fetch_nz   (fq_vld[0]),
    .mis_hit    (mis_hit),
    .skid_empty (skid_empty),
    .skid_last  (skid_last),
    .st_q       (st_q),
    .push       (push),
    .pop        (pop),
    .flush      (flush),
    .fwd_en     (fwd_en),
    .fe_stall   (fe_stall)
  );

  dec_skid_fifo #(.BW(BW), .DEPTH(DEPTH)) u_skid (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .flush (flush),
    .din   (fq_bun),
    .dout  (skid_dout),
    .empty (skid_empty),
    .last  (skid_last),
    .ovf   (skid_ovf)
  );

  assign fe_squash  = fwd_en & mis_hit;
  assign fe_mispred = fe_squash;
  assign mode       = st_q;

  always_comb begin
    fe_npc = '0;
    for (int i = 0; i < W; i++) begin
      if (fwd_en && hit_vec[i]) fe_npc = fe_npc | s_npc[i];
    end
  end

  // R2
  fwd_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((({1'b0, rn_valid} + (W+1)'(1)) & {1'b0, rn_valid}) == '0));

  // R9
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R9
  mispred_sq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_squash |=> (mode == 3'd4));

  // R8
  squash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_any || mode == 3'd4) |-> (rn_valid == '0 && !fe_squash));
endmodule

// File: tb/dec_stall_ctl_test.sv
module dec_stall_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] fq_vld, fq_ctl, fq_res, fq_mis, fq_nosrc;
  logic [31:0] fq_tag;
  logic [63:0] fq_npc;
  logic stall_ren, stall_iex, stall_cmt, cmt_squash, cmt_rob_sq;
  logic [3:0] rn_valid, rn_ready;
  logic [31:0] rn_tag;
  logic fe_stall, fe_squash, fe_mispred, skid_ovf;
  logic [15:0] fe_npc;
  logic [2:0] mode;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_stall_ctl uut (
    .clk(clk), .rst_n(rst_n),
    .fq_vld(fq_vld), .fq_ctl(fq_ctl), .fq_res(fq_res), .fq_mis(fq_mis),
    .fq_nosrc(fq_nosrc), .fq_tag(fq_tag), .fq_npc(fq_npc),
    .stall_ren(stall_ren), .stall_iex(stall_iex), .stall_cmt(stall_cmt),
    .cmt_squash(cmt_squash), .cmt_rob_sq(cmt_rob_sq),
    .rn_valid(rn_valid), .rn_ready(rn_ready), .rn_tag(rn_tag),
    .fe_stall(fe_stall), .fe_squash(fe_squash), .fe_mispred(fe_mispred),
    .fe_npc(fe_npc), .mode(mode), .skid_ovf(skid_ovf)
  );

  typedef struct packed {
    logic [3:0]  vld, ctl, res, mis, nos;
    logic [7:0]  tag;
    logic [15:0] npc;
    logic [2:0]  stl;
    logic [1:0]  sq;
    logic [3:0]  e_val, e_rdy;
    logic        e_stall, e_fsq;
    logic [15:0] e_npc;
    logic [7:0]  e_tag;
    logic [2:0]  e_st;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    // R1 idle, empty bundle
    '{4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,8'h00,16'h0000,3'b000,2'b00, 4'b0000,4'b0000,1'b0,1'b0,16'h0000,8'h00,3'd0},
    // R2 R3 full prefix, ready tags
    '{4'b0111,4'b0000,4'b0000,4'b0000,4'b0101,8'h10,16'h0000,3'b000,2'b00, 4'b0111,4'b0101,1'b0,1'b0,16'h0000,8'h10,3'd1},
    // R2 hole at slot 2 stops forwarding
    '{4'b1011,4'b0000,4'b0000,4'b0000,4'b1111,8'h20,16'h0000,3'b000,2'b00, 4'b0011,4'b0011,1'b0,1'b0,16'h0000,8'h20,3'd1},
    // R4 rename stall, bundle A parked
    '{4'b1111,4'b0000,4'b0000,4'b0000,4'b0000,8'h30,16'h0000,3'b100,2'b00, 4'b0000,4'b0000,1'b1,1'b0,16'h0000,8'h00,3'd2},
    // R5 blocked, bundle B parked
    '{4'b0011,4'b0000,4'b0000,4'b0000,4'b0001,8'h40,16'h0000,3'b010,2'b00, 4'b0000,4'b0000,1'b1,1'b0,16'h0000,8'h00,3'd2},
    // R5 blocked, empty bundle
    '{4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,8'h00,16'h0000,3'b001,2'b00, 4'b0000,4'b0000,1'b1,1'b0,16'h0000,8'h00,3'd2},
    // R6 release -> unblocking
    '{4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,8'h00,16'h0000,3'b000,2'b00, 4'b0000,4'b0000,1'b1,1'b0,16'h0000,8'h00,3'd3},
    // R7 replay A, fetch junk ignored
    '{4'b1111,4'b0000,4'b0000,4'b0000,4'b1111,8'h99,16'h0000,3'b000,2'b00, 4'b1111,4'b0000,1'b1,1'b0,16'h0000,8'h30,3'd3},
    // R7 replay B, last one
    '{4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,8'h00,16'h0000,3'b000,2'b00, 4'b0011,4'b0001,1'b0,1'b0,16'h0000,8'h40,3'd1},
    // R9 mispredict at slot 2
    '{4'b1111,4'b0110,4'b0110,4'b0100,4'b0000,8'h50,16'h0100,3'b000,2'b00, 4'b0111,4'b0000,1'b0,1'b1,16'h0102,8'h50,3'd4},
    // R8 rob squashing holds squashing
    '{4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,8'h00,16'h0000,3'b000,2'b01, 4'b0000,4'b0000,1'b0,1'b0,16'h0000,8'h00,3'd4},
    // R8 leave squashing, no forward
    '{4'b0011,4'b0000,4'b0000,4'b0000,4'b0000,8'h60,16'h0000,3'b000,2'b00, 4'b0000,4'b0000,1'b0,1'b0,16'h0000,8'h00,3'd1},
    // R8 squash beats stall
    '{4'b1111,4'b0000,4'b0000,4'b0000,4'b0000,8'h61,16'h0000,3'b111,2'b10, 4'b0000,4'b0000,1'b0,1'b0,16'h0000,8'h00,3'd4},
    '{4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,8'h00,16'h0000,3'b000,2'b00, 4'b0000,4'b0000,1'b0,1'b0,16'h0000,8'h00,3'd1},
    // R9 resolved, not mispredicted
    '{4'b1111,4'b1111,4'b1111,4'b0000,4'b1000,8'h70,16'h0300,3'b000,2'b00, 4'b1111,4'b1000,1'b0,1'b0,16'h0000,8'h70,3'd1},
    // R9 mispredict flag but unresolved
    '{4'b1111,4'b0001,4'b0000,4'b0001,4'b0000,8'h78,16'h0400,3'b000,2'b00, 4'b1111,4'b0000,1'b0,1'b0,16'h0000,8'h78,3'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v, c, r, m, n, input logic [7:0] tag,
                       input logic [15:0] npc, input logic [2:0] stl, input logic [1:0] sq);
    fq_vld = v; fq_ctl = c; fq_res = r; fq_mis = m; fq_nosrc = n;
    for (int i = 0; i < 4; i++) begin
      fq_tag[i*8 +: 8]   = tag + 8'(i);
      fq_npc[i*16 +: 16] = npc + 16'(i);
    end
    {stall_ren, stall_iex, stall_cmt} = stl;
    {cmt_squash, cmt_rob_sq} = sq;
    #1;
  endtask

  task automatic adv;
    @(posedge clk);
    #1;
  endtask

  task automatic idle_in;
    drive(4'b0, 4'b0, 4'b0, 4'b0, 4'b0, 8'h0, 16'h0, 3'b000, 2'b00);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_in();
    #(CLK_PERIOD * 2);
    chk("R1 mode", 32'(mode), 0);
    chk("R1 stall", 32'(fe_stall), 0);
    chk("R1 valid", 32'(rn_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    adv();

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k].vld, VEC[k].ctl, VEC[k].res, VEC[k].mis, VEC[k].nos,
            VEC[k].tag, VEC[k].npc, VEC[k].stl, VEC[k].sq);
      chk($sformatf("R2 valid v%0d", k), 32'(rn_valid), 32'(VEC[k].e_val));
      chk($sformatf("R3 ready v%0d", k), 32'(rn_ready), 32'(VEC[k].e_rdy));
      chk($sformatf("R4 stall v%0d", k), 32'(fe_stall), 32'(VEC[k].e_stall));
      chk($sformatf("R9 squash v%0d", k), 32'(fe_squash), 32'(VEC[k].e_fsq));
      if (VEC[k].e_fsq) begin
        chk($sformatf("R9 npc v%0d", k), 32'(fe_npc), 32'(VEC[k].e_npc));
        chk($sformatf("R9 mispred v%0d", k), 32'(fe_mispred), 1);
      end
      if (VEC[k].e_val[0]) chk($sformatf("R3 tag v%0d", k), 32'(rn_tag[7:0]), 32'(VEC[k].e_tag));
      chk($sformatf("R10 ovf v%0d", k), 32'(skid_ovf), 0);
      adv();
      chk($sformatf("R6 mode v%0d", k), 32'(mode), 32'(VEC[k].e_st));
    end

    // R1 reset in the middle of operation
    rst_n = 1'b0;
    idle_in();
    chk("R1 mode after mid reset", 32'(mode), 0);
    chk("R1 stall after mid reset", 32'(fe_stall), 0);
    @(negedge clk);
    rst_n = 1'b1;
    adv();

    // R10 fill to DEPTH, then R7 drain in order
    for (int k = 0; k < 4; k++) begin
      drive(4'b1111, 4'b0, 4'b0, 4'b0, 4'b0, 8'h80 + 8'(k * 16), 16'h0, 3'b100, 2'b00);
      chk("R10 no ovf while filling", 32'(skid_ovf), 0);
      adv();
      chk("R5 blocked while filling", 32'(mode), 2);
    end
    idle_in();
    adv();
    chk("R6 unblocking after fill", 32'(mode), 3);
    for (int k = 0; k < 4; k++) begin
      drive(4'b0001, 4'b0, 4'b0, 4'b0, 4'b0, 8'h11, 16'h0, 3'b000, 2'b00);
      chk("R7 replay order", 32'(rn_tag[7:0]), 32'(8'h80 + 8'(k * 16)));
      chk("R7 replay valid", 32'(rn_valid), 32'hF);
      chk("R7 stall during drain", 32'(fe_stall), (k < 3) ? 1 : 0);
      adv();
    end
    chk("R7 running after drain", 32'(mode), 1);

    // R8 squash empties parked bundles
    drive(4'b0001, 4'b0, 4'b0, 4'b0, 4'b0, 8'hC1, 16'h0, 3'b010, 2'b00);
    adv();
    drive(4'b0001, 4'b0, 4'b0, 4'b0, 4'b0, 8'hC2, 16'h0, 3'b010, 2'b00);
    adv();
    drive(4'b0, 4'b0, 4'b0, 4'b0, 4'b0, 8'h0, 16'h0, 3'b010, 2'b10);
    chk("R8 no forward on squash", 32'(rn_valid), 0);
    adv();
    chk("R8 squashing", 32'(mode), 4);
    idle_in();
    adv();
    chk("R8 back to running", 32'(mode), 1);
    drive(4'b0, 4'b0, 4'b0, 4'b0, 4'b0, 8'h0, 16'h0, 3'b001, 2'b00);
    adv();
    idle_in();
    adv();
    chk("R8 skid emptied by squash", 32'(mode), 1);

    // R9 mispredict inside a replayed bundle flushes the rest
    drive(4'b0011, 4'b0001, 4'b0001, 4'b0001, 4'b0, 8'hD0, 16'h0200, 3'b100, 2'b00);
    adv();
    drive(4'b0001, 4'b0, 4'b0, 4'b0, 4'b0, 8'hE0, 16'h0, 3'b100, 2'b00);
    adv();
    idle_in();
    adv();
    chk("R6 unblocking before replay", 32'(mode), 3);
    idle_in();
    chk("R9 replay cut after bad slot", 32'(rn_valid), 1);
    chk("R9 replay redirect", 32'(fe_squash), 1);
    chk("R9 replay npc", 32'(fe_npc), 32'h0200);
    adv();
    chk("R9 squashing after replay hit", 32'(mode), 4);
    idle_in();
    adv();
    drive(4'b0, 4'b0, 4'b0, 4'b0, 4'b0, 8'h0, 16'h0, 3'b100, 2'b00);
    adv();
    idle_in();
    adv();
    chk("R9 skid flushed by mispredict", 32'(mode), 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule